// File: doc/BRIEF.md
# Strobe-Clocked Serial Register Slave

This block is the device end of a four-wire serial link that lets a host read and write a small bank of registers using plain general-purpose pins. The host drives an active-low clear line, a strobe that acts as the bit clock, and a data-in line. The slave drives one data-out line. The slave runs on its own fast system clock. It brings every host wire through a two-flop synchronizer and finds strobe edges in those synchronized samples, so the host may toggle the pins at any rate slower than a few system clocks.

A transaction starts with a low pulse on clear, which drops any partial transfer. The host then clocks in a command word of ADDR_W+1 bits, most significant bit first. The top bit of the command selects a read and the lower bits carry the register address.

- **Read:** the host leaves strobe low after the command. It then pulses strobe REG_W times and samples data-out after each falling edge.
- **Write:** the host sends REG_W more data bits, and the register changes only once the last of them has arrived.

The low bits of one register drive LED outputs directly.

Top module: `strobe_reg_slave`

## Requirements
- R1: After reset, data-out is low, every LED output is low, and every register reads as zero.
- R2: A write of REG_W data bits, sent most significant bit first on strobe rising edges, is returned unchanged by a later read, most significant bit first.
- R3: The command word has ADDR_W+1 bits and is sent most significant bit first. Bit ADDR_W is 1 for a read and 0 for a write. Bits ADDR_W-1..0 hold the register address.
- R4: Addresses at or above NUM_REGS read as zero. Writes to them change no implemented register.
- R5: A write cut short by a clear pulse before its last data bit leaves the addressed register unchanged.
- R6: A clear pulse during the read phase abandons that read, and the next transaction is decoded from its first command bit.
- R7: LED output i follows bit i of register LED_ADDR, for i from 0 to LED_W-1. The outputs change only when the last bit of a write completes, never before.
- R8: Data-out is low while clear is low and throughout the command and write phases.
- R9: Data-out changes only right after a synchronized strobe rising edge or while clear is low, so it is stable across each strobe falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_n_pin | input | 1 | Host clear line, active low, resets framing |
| stb_pin | input | 1 | Host strobe, bit clock, idles high |
| din_pin | input | 1 | Host command and write data |
| dout_pin | output | 1 | Read data to host, low when idle |
| led | output | LED_W | LED drive from the low bits of register LED_ADDR |

## Verification
A wrong bit counter or phase value shows up at the ports within one transaction. The read word comes back shifted, or the read and write roles get swapped, and the next read of a known register returns a value other than the one the model expects. A write committed early or late shows up as an LED change at the wrong strobe edge, so LED levels are sampled one bit before and one bit after the end of a write. A data-out value left over from an earlier transfer appears as a high level during a clear or a command phase. Such a value is visible within a few system clocks of the clear edge.

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave #(
  parameter int ADDR_W   = 7,
  parameter int REG_W    = 16,
  parameter int NUM_REGS = 8,
  parameter int LED_W    = 4,
  parameter int LED_ADDR = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n_pin,
  input  logic             stb_pin,
  input  logic             din_pin,
  output logic             dout_pin,
  output logic [LED_W-1:0] led
);
  localparam int CMD_W = ADDR_W + 1;
  localparam int MAXB  = (REG_W > CMD_W) ? REG_W : CMD_W;
  localparam int CW    = $clog2(MAXB + 1);
  localparam int IW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  typedef enum logic [1:0] {P_CMD, P_RD, P_WR, P_DONE} phase_t;

  logic [1:0] clr_q, din_q;
  logic [2:0] stb_q;
  logic       clr_s, din_s, rise;

  phase_t            phase;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] cmd_sh, addr;
  logic [REG_W-1:0]  rd_sh, wr_sh;
  logic [REG_W-1:0]  regs [NUM_REGS];

  logic [CMD_W-1:0]  cmd_word;
  logic [ADDR_W-1:0] cmd_addr;
  logic [REG_W-1:0]  rd_word, wr_word;

  assign clr_s    = clr_q[1];
  assign din_s    = din_q[1];
  assign rise     = stb_q[1] & ~stb_q[2];
  assign cmd_word = {cmd_sh, din_s};
  assign cmd_addr = cmd_word[ADDR_W-1:0];
  assign rd_word  = (cmd_addr < ADDR_W'(NUM_REGS)) ? regs[cmd_addr[IW-1:0]] : '0;
  assign wr_word  = {wr_sh[REG_W-2:0], din_s};
  assign led      = regs[LED_ADDR][LED_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= '0;
      din_q <= '0;
      stb_q <= '1;
    end else begin
      clr_q <= {clr_q[0], clr_n_pin};
      din_q <= {din_q[0], din_pin};
      stb_q <= {stb_q[1:0], stb_pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= P_CMD;
      cnt      <= '0;
      cmd_sh   <= '0;
      addr     <= '0;
      rd_sh    <= '0;
      wr_sh    <= '0;
      dout_pin <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (!clr_s) begin
      phase    <= P_CMD;
      cnt      <= '0;
      dout_pin <= 1'b0;
    end else if (rise) begin
      case (phase)
        P_CMD: begin
          cmd_sh <= cmd_word[ADDR_W-1:0];
          if (cnt == CW'(ADDR_W)) begin
            cnt  <= '0;
            addr <= cmd_addr;
            if (cmd_word[ADDR_W]) begin
              rd_sh <= rd_word;
              phase <= P_RD;
            end else begin
              phase <= P_WR;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        P_RD: begin
          dout_pin <= rd_sh[REG_W-1];
          rd_sh    <= rd_sh << 1;
          cnt      <= cnt + 1'b1;
          if (cnt == CW'(REG_W-1)) phase <= P_DONE;
        end
        P_WR: begin
          wr_sh <= wr_word;
          if (cnt == CW'(REG_W-1)) begin
            if (addr < ADDR_W'(NUM_REGS)) regs[addr[IW-1:0]] <= wr_word;
            phase <= P_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: dout_pin <= 1'b0;
      endcase
    end
  end
endmodule

module strobe_reg_slave_chk #(
  parameter int LED_W = 4,
  parameter int REG_W = 16,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_s,
  input logic             rise,
  input logic [1:0]       phase,
  input logic [CW-1:0]    cnt,
  input logic             dout_pin,
  input logic [LED_W-1:0] led
);
  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> (!dout_pin && led == '0));

  a_r8_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> !dout_pin);

  a_r8_cmd_wr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 || phase == 2'd2) |-> !dout_pin);

  a_r9_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_pin) |-> $past(rise || !clr_s));

  a_r7_led_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led) |-> $past(rise && clr_s && phase == 2'd2));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(REG_W));
endmodule

bind strobe_reg_slave strobe_reg_slave_chk #(.LED_W(LED_W), .REG_W(REG_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .rise(rise), .phase(phase),
  .cnt(cnt), .dout_pin(dout_pin), .led(led)
);

// File: tb/strobe_reg_slave_tb.sv
module strobe_reg_slave_tb;
  localparam int ADDR_W = 7;
  localparam int REG_W  = 16;
  localparam int NREGS  = 8;
  localparam int LED_W  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr_n = 1'b1, stb = 1'b1, din = 1'b0;
  logic dout;
  logic [LED_W-1:0] led;
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [REG_W-1:0] mdl [1 << ADDR_W];
  logic [REG_W-1:0] exp_q[$], got_q[$];
  string            tag_q[$];

  always #2 clk = ~clk;

  strobe_reg_slave #(.ADDR_W(ADDR_W), .REG_W(REG_W), .NUM_REGS(NREGS), .LED_W(LED_W), .LED_ADDR(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n_pin(clr_n), .stb_pin(stb), .din_pin(din),
    .dout_pin(dout), .led(led)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hold();
    repeat (5) @(negedge clk);
  endtask

  task automatic start_txn();
    stb = 1'b1; hold();
    clr_n = 1'b0; hold();
    chk(dout == 1'b0, "R8 dout low during clear", dout, 0);
    clr_n = 1'b1; hold();
  endtask

  task automatic send_bit(input logic b);
    stb = 1'b0; din = b; hold();
    stb = 1'b1; hold();
  endtask

  task automatic send_cmd(input logic rd, input logic [ADDR_W-1:0] a);
    logic [ADDR_W:0] w;
    w = {rd, a};
    for (int i = ADDR_W; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] v);
    start_txn();
    send_cmd(1'b0, a);
    chk(dout == 1'b0, "R8 dout low in write phase", dout, 0);
    for (int i = REG_W - 1; i >= 0; i--) send_bit(v[i]);
    if (a < NREGS) mdl[a] = v;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
    logic [REG_W-1:0] got;
    exp_q.push_back(mdl[a]);
    tag_q.push_back(tag);
    start_txn();
    send_cmd(1'b1, a);
    stb = 1'b0; hold();
    got = '0;
    for (int i = REG_W - 1; i >= 0; i--) begin
      stb = 1'b1; hold();
      stb = 1'b0; hold();
      got[i] = dout;
    end
    stb = 1'b1; hold();
    got_q.push_back(got);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [REG_W-1:0] g, e;
        string t;
        g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(g == e, t, g, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mdl[i] = '0;
    repeat (4) @(negedge clk);
    chk(dout == 1'b0, "R1 dout after reset", dout, 0);
    chk(led == '0, "R1 led after reset", led, 0);
    rst_n = 1'b1;
    hold();
    for (int i = 0; i < NREGS; i++) rd(ADDR_W'(i), "R1 register zero after reset");

    wr(7'd3, 16'hA5C3);
    rd(7'd3, "R2 write/read pattern A5C3");
    wr(7'd5, 16'h8001);
    rd(7'd5, "R2 MSB and LSB set");
    wr(7'd6, 16'h7FFE);
    rd(7'd6, "R2 inverse edge pattern");
    rd(7'd3, "R3 address decode keeps reg3");

    wr(7'd8, 16'hFFFF);
    rd(7'd8, "R4 unimplemented address reads zero");
    rd(7'd0, "R4 aliased write left reg0 alone");
    rd(7'h7F, "R4 top address reads zero");

    start_txn();
    send_cmd(1'b0, 7'd3);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    rd(7'd3, "R5 partial write discarded");

    start_txn();
    send_cmd(1'b1, 7'd5);
    stb = 1'b0; hold();
    for (int i = 0; i < 3; i++) begin stb = 1'b1; hold(); stb = 1'b0; hold(); end
    rd(7'd6, "R6 read after aborted read");

    begin
      logic [REG_W-1:0] v;
      v = 16'h123A;
      start_txn();
      send_cmd(1'b0, 7'd0);
      for (int i = REG_W - 1; i >= 1; i--) send_bit(v[i]);
      chk(led == '0, "R7 led unchanged before last bit", led, 0);
      send_bit(v[0]);
      chk(led == 4'hA, "R7 led after write commit", led, 4'hA);
      mdl[0] = v;
    end
    wr(7'd0, 16'h0005);
    chk(led == 4'h5, "R7 led follows reg0 low bits", led, 4'h5);
    rd(7'd0, "R2 reg0 readback");

    wr(7'd1, 16'hFFFF);
    rd(7'd1, "R9 all-ones read");
    start_txn();
    chk(dout == 1'b0, "R8 dout low after new clear", dout, 0);

    repeat (10) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule